// File: doc/BRIEF.md
# Chainable Event Counter Bank

A bank of eight 32-bit counters for one slice of a shared cache's performance monitor. Each counter has an 8-bit selector. The selector ties the counter to the clock, to one of several single-cycle event pulse inputs, or to nothing. Software reaches the bank through a simple register port. Writes take effect at the clock edge on which they are presented. Reads return data on the clock edge after the request.

Odd counters can be chained to their even neighbour. A chained odd counter then advances once per carry out of the even counter, so the pair forms one 64-bit count. Each half of the pair is still loaded and read as its own 32-bit register. Counter enables and interrupt enables each have a write-one-to-set register and a write-one-to-clear register. Overflows collect in a sticky status register that software clears by writing ones. The interrupt line is a level output. A per-counter option flags an overflow on every toggle of the most significant bit, which lets a 32-bit counter run freely and be sampled at half-range intervals.

A small run controller holds the bank in one of three states. In HALT nothing counts. In COUNT the enabled counters advance. WIPE lasts one cycle and zeroes all counts and the status. A control write moves the controller from HALT or COUNT to WIPE when bit 1 is set. Otherwise the write moves it to COUNT if bit 0 is set and to HALT if bit 0 is clear. WIPE always leaves on the next edge, to COUNT or HALT according to the bit 0 that was written along with the reset request.

Top module: `event_counter_bank`

## Requirements
- R1: After reset, all counts, enable masks, interrupt masks, chain and MSB-mode masks, selectors and status bits are zero, the controller is in HALT, and `irq` is low.
- R2: The control register sits at 0x500, and its bit 0 selects COUNT. While the controller is not in COUNT, no counter changes except through a software load. Reading 0x500 returns 1 in bit 0 only while in COUNT.
- R3: A write to 0x500 with bit 1 set enters WIPE on the next edge. The following edge zeroes every count and every status bit, and leaves WIPE for COUNT if the written bit 0 was 1, or for HALT if it was 0. Enable and interrupt masks are kept.
- R4: The counter enable mask is set by writing ones to 0x508 and cleared by writing ones to 0x50C. Bit n belongs to counter n, zero bits have no effect, and both addresses read back the mask. A disabled counter does not advance.
- R5: The selector of counter n is at 0x220+8n, using its low 8 bits. Code 0x01 advances the counter on every clock in COUNT. Code 0x02+k advances it on each cycle in which `evt_in[k]` is high. Any other code advances nothing.
- R6: The count of counter n is at 0x420+8n. A write loads the value directly. A load and an increment in the same cycle leave the loaded value.
- R7: An increment from 0xFFFFFFFF gives 0 and sets status bit n in the register at 0x740.
- R8: When bit n of the MSB-mode register at 0x96C is set, every increment that changes bit 31 of counter n sets status bit n, including 0x7FFFFFFF to 0x80000000. With the bit clear, that step sets nothing.
- R9: Setting bit n of the chain register at 0x718, for odd n, makes counter n advance once for each carry out of counter n-1 (an increment of n-1 from all ones), and it then ignores its own selector. Even bits cannot be set and read as 0.
- R10: Writing ones to 0x740 clears those status bits, and zero bits have no effect. If a counter sets a status bit in the same cycle that the bit is cleared, the bit ends up set.
- R11: The interrupt mask is set through 0x510 and cleared through 0x514. Both addresses read back the mask. `irq` is high whenever any status bit and its mask bit are both set, and it stays high until the status bit or the mask bit is cleared.
- R12: `bus_rdata` is updated on the clock edge that samples `bus_rd` and holds its value until the next read. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_rd | input | 1 | Register read strobe, one cycle per read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| evt_in | input | 6 | Event pulses, one bit per source, counted when high at an edge |
| irq | output | 1 | Level interrupt request |

## Verification
Register writes act on the edge where the strobe is sampled. An event pulse advances its counter on that same edge. Status bits therefore change on the pulse's edge, and `irq` follows combinationally, so the bench reads `irq` at the falling edge right after the stimulus. A read's data lands one edge after the request. The driver queues each expected read value when it issues the request, and the monitor compares it at the next falling edge. The run controller adds one cycle of delay: a counter in COUNT advances for every edge from the one after the enabling write up to and including the edge of the disabling write. The cycle-count and load-versus-increment cases are computed from that rule.

// File: rtl/ecb_pkg.sv
package ecb_pkg;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_COUNT = 2'd1,
        ST_WIPE  = 2'd2
    } run_state_t;

    localparam logic [11:0] A_CTRL     = 12'h500;
    localparam logic [11:0] A_EN_SET   = 12'h508;
    localparam logic [11:0] A_EN_CLR   = 12'h50C;
    localparam logic [11:0] A_IE_SET   = 12'h510;
    localparam logic [11:0] A_IE_CLR   = 12'h514;
    localparam logic [11:0] A_CHAIN    = 12'h718;
    localparam logic [11:0] A_OVF      = 12'h740;
    localparam logic [11:0] A_MSB      = 12'h96C;
    localparam logic [11:0] A_SEL_BASE = 12'h220;
    localparam logic [11:0] A_CNT_BASE = 12'h420;
    localparam logic [11:0] A_STRIDE   = 12'h008;

    localparam logic [7:0] CODE_CYCLES = 8'h01;
    localparam logic [7:0] CODE_PIN0   = 8'h02;

endpackage

// File: rtl/ecb_ctrl_fsm.sv
module ecb_ctrl_fsm
    import ecb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_go,
    input  logic ctl_clr,
    output logic run,
    output logic wipe
);

    run_state_t state_q, state_d;
    logic       go_q, go_d;

    always_comb begin
        state_d = state_q;
        go_d    = go_q;
        unique case (state_q)
            ST_HALT:  state_d = ST_HALT;
            ST_COUNT: state_d = ST_COUNT;
            ST_WIPE:  state_d = go_q ? ST_COUNT : ST_HALT;
            default:  state_d = ST_HALT;
        endcase
        if (ctl_wr) begin
            go_d    = ctl_go;
            state_d = ctl_clr ? ST_WIPE : (ctl_go ? ST_COUNT : ST_HALT);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            go_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            go_q    <= go_d;
        end
    end

    always_comb begin
        run  = (state_q == ST_COUNT);
        wipe = (state_q == ST_WIPE);
    end

    // R3: WIPE lasts exactly one cycle unless a new reset request arrives
    assert_wipe_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WIPE && !(ctl_wr && ctl_clr)) |=> (state_q != ST_WIPE));

endmodule

// File: rtl/ecb_counter.sv
module ecb_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wipe,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    input  logic         msb_mode,
    output logic [W-1:0] value,
    output logic         flag
);

    logic adv;

    assign adv  = inc && !load && !wipe;
    assign flag = adv && (msb_mode ? (&value[W-2:0]) : (&value));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (wipe) begin
            value <= '0;
        end else if (load) begin
            value <= load_val;
        end else if (adv) begin
            value <= value + W'(1);
        end
    end

    // R7: a wrap flag outside MSB mode is always followed by a zero count
    assert_wrap_to_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !msb_mode) |=> (value == '0));

endmodule

// File: rtl/event_counter_bank.sv
module event_counter_bank
    import ecb_pkg::*;
#(
    parameter int N_CNT = 8,
    parameter int CNT_W = 32,
    parameter int N_EVT = 6,
    parameter int SEL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [11:0]      bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic [N_EVT-1:0] evt_in,
    output logic             irq
);

    localparam int N_PAIR = N_CNT / 2;

    function automatic logic [N_CNT-1:0] odd_bits();
        logic [N_CNT-1:0] r;
        for (int i = 0; i < N_CNT; i++) r[i] = (i % 2 == 1);
        return r;
    endfunction
    localparam logic [N_CNT-1:0] ODD_MASK = odd_bits();

    logic run, wipe;
    logic [N_CNT-1:0] en_q, ie_q, chain_q, msb_q, ovf_q;
    logic [N_CNT-1:0][SEL_W-1:0] sel_q;
    logic [N_CNT-1:0][CNT_W-1:0] cnt_val;
    logic [N_CNT-1:0] hit, inc, flag, sel_hit, cnt_hit, sel_wr, cnt_wr;
    logic [N_CNT-1:0] wmask;
    logic wr_ctrl, wr_en_set, wr_en_clr, wr_ie_set, wr_ie_clr, wr_chain, wr_ovf, wr_msb;
    logic [CNT_W-1:0] rd_d;

    assign wmask     = bus_wdata[N_CNT-1:0];
    assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
    assign wr_en_set = bus_wr && (bus_addr == A_EN_SET);
    assign wr_en_clr = bus_wr && (bus_addr == A_EN_CLR);
    assign wr_ie_set = bus_wr && (bus_addr == A_IE_SET);
    assign wr_ie_clr = bus_wr && (bus_addr == A_IE_CLR);
    assign wr_chain  = bus_wr && (bus_addr == A_CHAIN);
    assign wr_ovf    = bus_wr && (bus_addr == A_OVF);
    assign wr_msb    = bus_wr && (bus_addr == A_MSB);

    ecb_ctrl_fsm u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_wr  (wr_ctrl),
        .ctl_go  (bus_wdata[0]),
        .ctl_clr (bus_wdata[1]),
        .run     (run),
        .wipe    (wipe)
    );

    // event source selection
    always_comb begin
        for (int n = 0; n < N_CNT; n++) begin
            hit[n] = (sel_q[n] == SEL_W'(CODE_CYCLES));
            for (int k = 0; k < N_EVT; k++) begin
                if (sel_q[n] == SEL_W'(CODE_PIN0 + k)) hit[n] = evt_in[k];
            end
        end
    end

    // increment, with the odd counter optionally taking the even carry
    always_comb begin
        for (int p = 0; p < N_PAIR; p++) begin
            inc[2*p]   = run && en_q[2*p] && hit[2*p];
            inc[2*p+1] = run && en_q[2*p+1] &&
                         (chain_q[2*p+1] ?
                          (run && en_q[2*p] && hit[2*p] && !cnt_wr[2*p] && (&cnt_val[2*p])) :
                          hit[2*p+1]);
        end
    end

    for (genvar n = 0; n < N_CNT; n++) begin : g_cnt
        assign sel_hit[n] = (bus_addr == A_SEL_BASE + A_STRIDE * 12'(n));
        assign cnt_hit[n] = (bus_addr == A_CNT_BASE + A_STRIDE * 12'(n));
        assign sel_wr[n]  = bus_wr && sel_hit[n];
        assign cnt_wr[n]  = bus_wr && cnt_hit[n];

        ecb_counter #(.W(CNT_W)) u_counter (
            .clk      (clk),
            .rst_n    (rst_n),
            .wipe     (wipe),
            .load     (cnt_wr[n]),
            .load_val (bus_wdata),
            .inc      (inc[n]),
            .msb_mode (msb_q[n]),
            .value    (cnt_val[n]),
            .flag     (flag[n])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            ie_q    <= '0;
            chain_q <= '0;
            msb_q   <= '0;
            ovf_q   <= '0;
            sel_q   <= '0;
        end else begin
            if (wr_en_set)      en_q <= en_q | wmask;
            else if (wr_en_clr) en_q <= en_q & ~wmask;
            if (wr_ie_set)      ie_q <= ie_q | wmask;
            else if (wr_ie_clr) ie_q <= ie_q & ~wmask;
            if (wr_chain) chain_q <= wmask & ODD_MASK;
            if (wr_msb)   msb_q   <= wmask;
            for (int n = 0; n < N_CNT; n++) begin
                if (sel_wr[n]) sel_q[n] <= bus_wdata[SEL_W-1:0];
            end
            if (wipe) ovf_q <= '0;
            else      ovf_q <= (ovf_q & ~(wr_ovf ? wmask : '0)) | flag;
        end
    end

    assign irq = |(ovf_q & ie_q);

    // read path
    always_comb begin
        rd_d = '0;
        case (bus_addr)
            A_CTRL:             rd_d[0] = run;
            A_EN_SET, A_EN_CLR: rd_d[N_CNT-1:0] = en_q;
            A_IE_SET, A_IE_CLR: rd_d[N_CNT-1:0] = ie_q;
            A_CHAIN:            rd_d[N_CNT-1:0] = chain_q;
            A_OVF:              rd_d[N_CNT-1:0] = ovf_q;
            A_MSB:              rd_d[N_CNT-1:0] = msb_q;
            default:            rd_d = '0;
        endcase
        for (int n = 0; n < N_CNT; n++) begin
            if (sel_hit[n]) rd_d = CNT_W'(sel_q[n]);
            if (cnt_hit[n]) rd_d = cnt_val[n];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_d;
    end

    // R4: ones written to the set address are present in the mask afterwards
    assert_enable_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_set |=> ((en_q & $past(wmask)) == $past(wmask)));

    // R2: outside COUNT and without a write, all counts hold
    assert_halt_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wipe && !bus_wr) |=> $stable(cnt_val));

    // R10: a status bit only falls after a status write or a WIPE cycle
    assert_status_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(ovf_q) & ~ovf_q)) |-> ($past(wr_ovf) || $past(wipe)));

    // R11: the interrupt level holds while no register write occurs
    assert_irq_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !bus_wr && !wipe) |=> irq);

endmodule

// File: tb/test_event_counter_bank.sv
`timescale 1ns/1ps
module test_event_counter_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  evt_in = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic rd_pend = 1'b0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    event_counter_bank i_event_counter_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_in(evt_in), .irq(irq)
    );

    function automatic void check(logic [31:0] act, logic [31:0] exp, string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endfunction

    function automatic logic [11:0] a_cnt(int n);
        return 12'h420 + 12'(8 * n);
    endfunction
    function automatic logic [11:0] a_sel(int n);
        return 12'h220 + 12'(8 * n);
    endfunction

    // monitor: compare read data one edge after the request
    always @(posedge clk) rd_pend <= bus_rd;
    always @(negedge clk) begin : mon
        logic [31:0] e;
        string t;
        if (rd_pend) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(bus_rdata, e, t);
        end
    end

    // all tasks are entered at a falling edge and return at the next one
    task automatic wr(logic [11:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(logic [5:0] m);
        evt_in = m;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check({31'd0, irq}, 32'd0, "R1 irq after reset");
        rd(a_cnt(0), 32'd0, "R1 count0 after reset");
        rd(12'h500, 32'd0, "R1 control after reset");
        rd(12'h508, 32'd0, "R1 enables after reset");
        rd(12'h740, 32'd0, "R1 status after reset");

        // R4 set/clear enables
        wr(12'h508, 32'h0F);
        rd(12'h508, 32'h0F, "R4 enable set");
        wr(12'h50C, 32'h05);
        rd(12'h50C, 32'h0A, "R4 enable clear");
        wr(12'h508, 32'h00);
        rd(12'h508, 32'h0A, "R4 zero write no effect");
        wr(12'h50C, 32'hFF);

        // R5 event selection, R2 halt
        wr(a_sel(0), 32'h02);
        wr(a_sel(1), 32'h03);
        wr(a_sel(2), 32'h7F);
        wr(a_sel(3), 32'h02);
        rd(a_sel(1), 32'h03, "R5 selector readback");
        wr(12'h508, 32'h07);
        wr(12'h500, 32'h01);
        for (int i = 0; i < 5; i++) pulse(6'b000001);
        for (int i = 0; i < 3; i++) pulse(6'b000010);
        wr(12'h500, 32'h00);
        rd(12'h500, 32'd0, "R2 control reads halt");
        for (int i = 0; i < 4; i++) pulse(6'b000001);
        rd(a_cnt(0), 32'd5, "R5 pin0 count, R2 frozen in halt");
        rd(a_cnt(1), 32'd3, "R5 pin1 count");
        rd(a_cnt(2), 32'd0, "R5 unused code counts nothing");
        rd(a_cnt(3), 32'd0, "R4 disabled counter");

        // R5 cycle code
        wr(a_cnt(4), 32'h100);
        wr(a_sel(4), 32'h01);
        wr(12'h508, 32'h10);
        wr(12'h500, 32'h01);
        rd(12'h500, 32'h01, "R2 control reads count");
        repeat (8) @(negedge clk);
        wr(12'h500, 32'h00);
        rd(a_cnt(4), 32'h10A, "R5 cycle code counts every clock");

        // R6 load beats increment
        wr(12'h500, 32'h01);
        wr(a_cnt(4), 32'h55);
        wr(12'h500, 32'h00);
        rd(a_cnt(4), 32'h56, "R6 load wins over increment");
        wr(a_cnt(0), 32'h1234);
        rd(a_cnt(0), 32'h1234, "R6 direct load");

        // R7 wrap, R11 interrupt
        wr(12'h50C, 32'hFF);
        wr(a_cnt(0), 32'hFFFF_FFFE);
        wr(12'h508, 32'h01);
        wr(12'h510, 32'h01);
        wr(12'h500, 32'h01);
        pulse(6'b000001);
        check({31'd0, irq}, 32'd0, "R11 no irq before wrap");
        pulse(6'b000001);
        check({31'd0, irq}, 32'd1, "R11 irq on wrap");
        wr(12'h500, 32'h00);
        rd(a_cnt(0), 32'd0, "R7 wrap to zero");
        rd(12'h740, 32'h01, "R7 status bit set");
        repeat (3) @(negedge clk);
        check({31'd0, irq}, 32'd1, "R11 irq holds level");
        wr(12'h514, 32'h01);
        check({31'd0, irq}, 32'd0, "R11 mask clear drops irq");
        rd(12'h514, 32'h00, "R11 mask readback");
        wr(12'h510, 32'h01);
        check({31'd0, irq}, 32'd1, "R11 mask set raises irq");
        wr(12'h740, 32'h00);
        check({31'd0, irq}, 32'd1, "R10 zero write keeps status");
        wr(12'h740, 32'h01);
        check({31'd0, irq}, 32'd0, "R10 write one clears status");

        // R10 set wins over clear
        wr(a_cnt(0), 32'hFFFF_FFFF);
        wr(12'h500, 32'h01);
        evt_in = 6'b000001;
        bus_wr = 1'b1; bus_addr = 12'h740; bus_wdata = 32'h01;
        @(negedge clk);
        evt_in = '0; bus_wr = 1'b0;
        wr(12'h500, 32'h00);
        rd(12'h740, 32'h01, "R10 set wins over clear");
        wr(12'h740, 32'hFF);

        // R8 MSB toggle mode
        wr(12'h96C, 32'h02);
        rd(12'h96C, 32'h02, "R8 mode readback");
        wr(12'h508, 32'h02);
        wr(a_cnt(0), 32'h7FFF_FFFF);
        wr(a_cnt(1), 32'h7FFF_FFFF);
        wr(12'h500, 32'h01);
        pulse(6'b000011);
        wr(12'h500, 32'h00);
        rd(a_cnt(1), 32'h8000_0000, "R8 count crosses half range");
        rd(12'h740, 32'h02, "R8 toggle flags only in MSB mode");
        wr(12'h740, 32'hFF);

        // R9 chaining
        wr(12'h718, 32'hFF);
        rd(12'h718, 32'hAA, "R9 even chain bits read zero");
        wr(12'h718, 32'h08);
        wr(12'h50C, 32'hFF);
        wr(12'h508, 32'h0C);
        wr(a_sel(2), 32'h02);
        wr(a_sel(3), 32'h03);
        wr(a_cnt(2), 32'hFFFF_FFFE);
        wr(a_cnt(3), 32'd5);
        wr(12'h500, 32'h01);
        pulse(6'b000010);
        pulse(6'b000001);
        pulse(6'b000011);
        wr(12'h500, 32'h00);
        rd(a_cnt(2), 32'd0, "R9 low half wrapped");
        rd(a_cnt(3), 32'd6, "R9 high half counts carries only");
        rd(12'h740, 32'h04, "R9 low half status");

        // R3 unit reset
        wr(12'h500, 32'h03);
        @(negedge clk);
        rd(12'h500, 32'h01, "R3 wipe exits to count");
        wr(12'h500, 32'h00);
        rd(a_cnt(3), 32'd0, "R3 count zeroed");
        rd(a_cnt(4), 32'd0, "R3 other count zeroed");
        rd(12'h740, 32'd0, "R3 status zeroed");
        rd(12'h508, 32'h0C, "R3 enables kept");
        rd(12'h600, 32'd0, "R12 unmapped reads zero");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule